// File: doc/BRIEF.md
# Dual-Loop Framed Payload Demultiplexer

This block receives two serial line streams. Each stream has its own bit-enable, and each carries half of one payload. Every line is cut into fixed-length frames with the same layout, in time order. A frame opens with a sync pattern of `SYNC_LEN` bits, most significant bit first. One loop-identifier bit follows: 0 marks the first half and 1 marks the second half. Then come `PAY_LEN` payload bits, then `DL_LEN` data-link bits, and last a 6-bit check code. Each line finds its own frame alignment. The block detects a line that arrives bit-inverted and corrects it. It also detects when the two lines are cross-connected and puts the halves back in order.

Each line's data-link bits are removed from the payload path. They are queued per line for a processor, which pops them through a valid/ready port. For every pair of frames, the two payload halves are joined into one word in the original order. That word goes into an output FIFO, which is read through a valid/ready port. A consumer that holds `out_ready` low stalls the FIFO but never the lines. While the FIFO is full, each newly completed pair is discarded. The data-link queues follow the same rule.

Top module: `dlp_demux`

## Requirements
- R1: A line's `sync_locked` bit rises once it has seen two sync matches exactly one frame (`SYNC_LEN+1+PAY_LEN+DL_LEN+6` enabled bits) apart. Only frames that end after lock produce output, so the very first frame of a line is never delivered.
- R2: A locked line tolerates up to two consecutive frames with no sync match and stays locked. The third consecutive miss clears `sync_locked`.
- R3: The hunt also accepts the bitwise inverse of the sync word. When a line locks on the inverse, its `polarity_inv` bit reads 1. Every later bit of that line is re-inverted, so its payload, identifier and data-link values come out exactly as transmitted.
- R4: A frame pair is ordered by its identifier bits. If the frame from line 0 carries identifier 1, `loops_swapped` reads 1 and the line-1 payload is placed first. Otherwise the flag reads 0.
- R5: `out_data` carries the identifier-0 payload in bits [2*PAY_LEN-1:PAY_LEN] and the identifier-1 payload in bits [PAY_LEN-1:0]. Each half has its earliest-received bit in its most significant position.
- R6: The check code is CRC-6 with polynomial x^6+x+1. It starts at zero and runs over the identifier, payload and data-link bits in arrival order. The received code arrives MSB first. A mismatch gives a one-cycle pulse on that line's `crc_error` bit, and the payload is still forwarded.
- R7: Each locked frame's data-link bits (first-received bit as MSB) are queued for the physical line they came on. They appear on that line's slice `dl_data[g*DL_LEN +: DL_LEN]` and never in `out_data`.
- R8: `out_data` holds steady while `out_valid` is high and `out_ready` is low. A pair completed while the output FIFO is full is discarded, and the stored words come out in order.
- R9: A line bit sampled while its `line_en` bit is low is ignored, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_bit | input | 2 | Serial bit of line 0 (bit 0) and line 1 (bit 1) |
| line_en | input | 2 | Per-line bit-enable |
| out_valid | output | 1 | Merged word available |
| out_ready | input | 1 | Consumer takes the merged word |
| out_data | output | 2*PAY_LEN | Merged payload word |
| dl_valid | output | 2 | Per-line data-link entry available |
| dl_ready | input | 2 | Processor pops the per-line entry |
| dl_data | output | 2*DL_LEN | Per-line data-link entries |
| sync_locked | output | 2 | Per-line frame lock |
| polarity_inv | output | 2 | Per-line inverted-polarity indication (while locked) |
| loops_swapped | output | 1 | Last pair arrived cross-connected |
| crc_error | output | 2 | Per-line check-code mismatch pulse |

## Verification
Lock, polarity and the `crc_error` pulse change on the same edge that captures the deciding line bit. The bench counts CRC pulses over a whole run, so it never has to hit one exact cycle. A merged word reaches `out_valid` three edges after the later half's last bit:
1. the frame register,
2. the pairing hold,
3. the FIFO write.

A data-link entry appears two edges after its frame ends. The bench therefore drains at least twenty idle cycles after the last line bit before comparing its queued expectations. It samples every handshake on the falling edge, and it moves `out_ready` only just after a rising edge.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_CONFIRM, ST_LOCKED} sync_st_e;

  localparam int CRC_W = 6;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic d,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/dlp_loop_rx.sv
module dlp_loop_rx
  import dlp_pkg::*;
#(
  parameter int SYNC_LEN = 8,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = 8'hB2,
  parameter int PAY_LEN = 8,
  parameter int DL_LEN = 2,
  parameter logic [CRC_W-1:0] CRC_POLY = 6'h03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_i,
  input  logic               en_i,
  output logic               locked_o,
  output logic               inv_o,
  output logic               frm_valid_o,
  output logic               frm_id_o,
  output logic [PAY_LEN-1:0] frm_pay_o,
  output logic [DL_LEN-1:0]  frm_dl_o,
  output logic               crc_err_o
);
  localparam int FRAME_LEN = SYNC_LEN + 1 + PAY_LEN + DL_LEN + CRC_W;
  localparam int PW = $clog2(FRAME_LEN);
  localparam logic [PW-1:0] P_SEND = PW'(SYNC_LEN - 1);
  localparam logic [PW-1:0] P_ID   = PW'(SYNC_LEN);
  localparam logic [PW-1:0] P_PLO  = PW'(SYNC_LEN + 1);
  localparam logic [PW-1:0] P_PHI  = PW'(SYNC_LEN + PAY_LEN);
  localparam logic [PW-1:0] P_DHI  = PW'(SYNC_LEN + PAY_LEN + DL_LEN);
  localparam logic [PW-1:0] P_LAST = PW'(FRAME_LEN - 1);

  sync_st_e            st;
  logic                inv;
  logic [1:0]          miss;
  logic [PW-1:0]       pos, pos_inc, npos;
  logic [SYNC_LEN-1:0] win, win_n;
  logic                hit_pos, hit_neg, hit_cur, d;
  logic [CRC_W-1:0]    crc, rxc;
  logic [PAY_LEN-1:0]  pay;
  logic [DL_LEN-1:0]   dl;
  logic                id;

  always_comb begin
    win_n   = {win[SYNC_LEN-2:0], bit_i};
    hit_pos = (win_n == SYNC_WORD);
    hit_neg = (win_n == ~SYNC_WORD);
    hit_cur = inv ? hit_neg : hit_pos;
    pos_inc = (pos == P_LAST) ? '0 : pos + 1'b1;
    if (st == ST_HUNT) npos = (hit_pos || hit_neg) ? P_SEND : pos;
    else               npos = pos_inc;
    d = bit_i ^ inv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_HUNT;
      inv <= 1'b0;
      miss <= '0;
      pos <= '0;
      win <= '0;
      crc <= '0;
      rxc <= '0;
      pay <= '0;
      dl <= '0;
      id <= 1'b0;
      frm_valid_o <= 1'b0;
      frm_id_o <= 1'b0;
      frm_pay_o <= '0;
      frm_dl_o <= '0;
      crc_err_o <= 1'b0;
    end else begin
      frm_valid_o <= 1'b0;
      crc_err_o <= 1'b0;
      if (en_i) begin
        win <= win_n;
        pos <= npos;
        if (npos == P_SEND) crc <= '0;
        unique case (st)
          ST_HUNT: if (hit_pos || hit_neg) begin
            st <= ST_CONFIRM;
            inv <= hit_neg;
          end
          ST_CONFIRM: if (npos == P_SEND) begin
            st <= hit_cur ? ST_LOCKED : ST_HUNT;
            miss <= '0;
          end
          ST_LOCKED: if (npos == P_SEND) begin
            if (hit_cur) miss <= '0;
            else if (miss == 2'd2) begin
              st <= ST_HUNT;
              miss <= '0;
            end else miss <= miss + 1'b1;
          end
          default: st <= ST_HUNT;
        endcase
        if (st == ST_LOCKED) begin
          if (npos >= P_ID && npos <= P_DHI) crc <= crc_step(crc, d, CRC_POLY);
          if (npos == P_ID) id <= d;
          if (npos >= P_PLO && npos <= P_PHI) pay <= (pay << 1) | PAY_LEN'(d);
          if (npos > P_PHI && npos <= P_DHI) dl <= (dl << 1) | DL_LEN'(d);
          if (npos > P_DHI) rxc <= {rxc[CRC_W-2:0], d};
          if (npos == P_LAST) begin
            frm_valid_o <= 1'b1;
            frm_id_o <= id;
            frm_pay_o <= pay;
            frm_dl_o <= dl;
            crc_err_o <= ({rxc[CRC_W-2:0], d} != crc);
          end
        end
      end
    end
  end

  assign locked_o = (st == ST_LOCKED);
  assign inv_o = inv && locked_o;
endmodule

// File: rtl/dlp_fifo.sv
module dlp_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         full, do_wr, do_rd;

  assign full     = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign rd_valid = (wp != rp);
  assign rd_data  = mem[rp[AW-1:0]];
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[AW-1:0]] <= wr_data;
  end
endmodule

// File: rtl/dlp_pair_merge.sv
module dlp_pair_merge #(
  parameter int PAY_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           frm_valid,
  input  logic [1:0]           frm_id,
  input  logic [PAY_LEN-1:0]   pay0,
  input  logic [PAY_LEN-1:0]   pay1,
  output logic                 push,
  output logic [2*PAY_LEN-1:0] word,
  output logic                 swapped
);
  logic [1:0]         hv, hid;
  logic [PAY_LEN-1:0] hp0, hp1;

  assign push = &hv;
  assign word = hid[0] ? {hp1, hp0} : {hp0, hp1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv <= '0;
      hid <= '0;
      hp0 <= '0;
      hp1 <= '0;
      swapped <= 1'b0;
    end else begin
      if (push) begin
        hv <= '0;
        swapped <= hid[0];
      end
      if (frm_valid[0]) begin
        hv[0] <= 1'b1;
        hid[0] <= frm_id[0];
        hp0 <= pay0;
      end
      if (frm_valid[1]) begin
        hv[1] <= 1'b1;
        hid[1] <= frm_id[1];
        hp1 <= pay1;
      end
    end
  end
endmodule

// File: rtl/dlp_demux.sv
module dlp_demux
  import dlp_pkg::*;
#(
  parameter int SYNC_LEN = 8,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = 8'hB2,
  parameter int PAY_LEN = 8,
  parameter int DL_LEN = 2,
  parameter logic [CRC_W-1:0] CRC_POLY = 6'h03,
  parameter int OUT_DEPTH = 4,
  parameter int DL_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           line_bit,
  input  logic [1:0]           line_en,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*PAY_LEN-1:0] out_data,
  output logic [1:0]           dl_valid,
  input  logic [1:0]           dl_ready,
  output logic [2*DL_LEN-1:0]  dl_data,
  output logic [1:0]           sync_locked,
  output logic [1:0]           polarity_inv,
  output logic                 loops_swapped,
  output logic [1:0]           crc_error
);
  logic [1:0]           frm_v, frm_id;
  logic [PAY_LEN-1:0]   frm_pay [2];
  logic [DL_LEN-1:0]    frm_dl [2];
  logic                 push;
  logic [2*PAY_LEN-1:0] word;

  for (genvar g = 0; g < 2; g++) begin : g_line
    dlp_loop_rx #(
      .SYNC_LEN(SYNC_LEN), .SYNC_WORD(SYNC_WORD), .PAY_LEN(PAY_LEN),
      .DL_LEN(DL_LEN), .CRC_POLY(CRC_POLY)
    ) u_rx (
      .clk(clk), .rst_n(rst_n), .bit_i(line_bit[g]), .en_i(line_en[g]),
      .locked_o(sync_locked[g]), .inv_o(polarity_inv[g]),
      .frm_valid_o(frm_v[g]), .frm_id_o(frm_id[g]), .frm_pay_o(frm_pay[g]),
      .frm_dl_o(frm_dl[g]), .crc_err_o(crc_error[g])
    );

    dlp_fifo #(.W(DL_LEN), .DEPTH(DL_DEPTH)) u_dlq (
      .clk(clk), .rst_n(rst_n), .wr_en(frm_v[g]), .wr_data(frm_dl[g]),
      .rd_valid(dl_valid[g]), .rd_ready(dl_ready[g]),
      .rd_data(dl_data[g*DL_LEN +: DL_LEN])
    );
  end

  dlp_pair_merge #(.PAY_LEN(PAY_LEN)) u_merge (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_v), .frm_id(frm_id),
    .pay0(frm_pay[0]), .pay1(frm_pay[1]), .push(push), .word(word),
    .swapped(loops_swapped)
  );

  dlp_fifo #(.W(2*PAY_LEN), .DEPTH(OUT_DEPTH)) u_outq (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(word),
    .rd_valid(out_valid), .rd_ready(out_ready), .rd_data(out_data)
  );
endmodule

// File: rtl/dlp_checks.sv
module dlp_checks #(
  parameter int OUT_W = 16,
  parameter int DL_LEN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       line_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic [1:0]       dl_valid,
  input logic [1:0]       dl_ready,
  input logic [2*DL_LEN-1:0] dl_data,
  input logic [1:0]       sync_locked,
  input logic [1:0]       crc_error
);
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_DL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      dl_valid[g] && !dl_ready[g] |=> dl_valid[g] && $stable(dl_data[g*DL_LEN +: DL_LEN])); // R7
    AST_CRC_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      crc_error[g] |-> sync_locked[g]); // R6
    AST_CRC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      crc_error[g] |=> !crc_error[g]); // R6
    AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_locked[g]) |-> $past(line_en[g])); // R9
    AST_UNLOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_locked[g]) |-> $past(line_en[g])); // R2
  end
endmodule

bind dlp_demux dlp_checks #(.OUT_W(2*PAY_LEN), .DL_LEN(DL_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_en(line_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .dl_valid(dl_valid),
  .dl_ready(dl_ready), .dl_data(dl_data), .sync_locked(sync_locked),
  .crc_error(crc_error)
);

// File: tb/test_dlp_demux.sv
`timescale 1ns/1ps
module test_dlp_demux;
  localparam int SL = 8;
  localparam logic [7:0] SW = 8'hB2;
  localparam int FL = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] line_bit, line_en;
  logic out_valid, out_ready, loops_swapped;
  logic [15:0] out_data;
  logic [1:0] dl_valid, dl_ready, sync_locked, polarity_inv, crc_error;
  logic [3:0] dl_data;

  dlp_demux i_dlp_demux (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .line_en(line_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .dl_valid(dl_valid), .dl_ready(dl_ready), .dl_data(dl_data),
    .sync_locked(sync_locked), .polarity_inv(polarity_inv),
    .loops_swapped(loops_swapped), .crc_error(crc_error)
  );

  always #2 clk = ~clk;

  logic lq0[$], lq1[$];
  logic [15:0] exp_w[$], got_w[$];
  logic [1:0] exp_d0[$], exp_d1[$], got_d0[$], got_d1[$];
  int crc_n0, crc_n1, cyc, gate_mode;
  int n_chk = 0, n_fail = 0;

  function automatic logic [5:0] crc_next(input logic [5:0] c, input logic b);
    return {c[4:0], 1'b0} ^ ((c[5] ^ b) ? 6'h03 : 6'h00);
  endfunction

  // driver and monitor, both on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (gate_mode == 0 || (cyc % 3) != 2) begin
      if (lq0.size() > 0) begin line_en[0] = 1'b1; line_bit[0] = lq0.pop_front(); end
      else begin line_en[0] = 1'b0; line_bit[0] = 1'($urandom); end
      if (lq1.size() > 0) begin line_en[1] = 1'b1; line_bit[1] = lq1.pop_front(); end
      else begin line_en[1] = 1'b0; line_bit[1] = 1'($urandom); end
    end else begin
      line_en = 2'b00;
      line_bit = 2'($urandom);
    end
    if (rst_n) begin
      if (out_valid && out_ready) got_w.push_back(out_data);
      if (dl_valid[0]) got_d0.push_back(dl_data[1:0]);
      if (dl_valid[1]) got_d1.push_back(dl_data[3:2]);
      if (crc_error[0]) crc_n0++;
      if (crc_error[1]) crc_n1++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_bits(input int line, input logic b);
    if (line == 0) lq0.push_back(b); else lq1.push_back(b);
  endtask

  task automatic idle(input int line, input int n, input logic v);
    for (int i = 0; i < n; i++) push_bits(line, v);
  endtask

  task automatic add_frame(input int line, input logic idb, input logic [7:0] pay,
                           input logic [1:0] dlv, input logic inv, input logic corrupt);
    logic f[$];
    logic [5:0] c;
    logic [10:0] body;
    c = '0;
    body = {idb, pay, dlv};
    for (int i = 7; i >= 0; i--) f.push_back(SW[i]);
    for (int i = 10; i >= 0; i--) begin
      f.push_back(body[i]);
      c = crc_next(c, body[i]);
    end
    for (int i = 5; i >= 0; i--) f.push_back(c[i]);
    if (corrupt) f[SL+1] = ~f[SL+1];
    foreach (f[i]) push_bits(line, f[i] ^ inv);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    lq0.delete(); lq1.delete();
    exp_w.delete(); got_w.delete();
    exp_d0.delete(); exp_d1.delete(); got_d0.delete(); got_d1.delete();
    crc_n0 = 0; crc_n1 = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic drain();
    while (lq0.size() > 0 || lq1.size() > 0) @(posedge clk);
    repeat (20) @(posedge clk);
    #1;
  endtask

  task automatic send_pairs(input int n, input logic id0, input logic inv0, input logic inv1,
                            input int bad_idx);
    idle(0, 4, inv0);
    idle(1, 9, inv1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] pa, pb;
      logic [1:0] da, db;
      pa = 8'($urandom); pb = 8'($urandom);
      da = 2'(i); db = ~2'(i);
      add_frame(0, id0, pa, da, inv0, 1'b0);
      add_frame(1, ~id0, pb, db, inv1, i == bad_idx);
      if (i == bad_idx) pb = pb ^ 8'h80;
      if (i >= 1) begin
        exp_w.push_back(id0 ? {pb, pa} : {pa, pb});
        exp_d0.push_back(da);
        exp_d1.push_back(db);
      end
    end
  endtask

  task automatic cmp_words(input string req);
    chk(got_w.size() == exp_w.size(), {req, " word count"}, got_w.size(), exp_w.size());
    if (got_w.size() == exp_w.size())
      foreach (exp_w[i]) chk(got_w[i] == exp_w[i], {req, " word"}, got_w[i], exp_w[i]);
  endtask

  task automatic cmp_dl(input string req);
    chk(got_d0.size() == exp_d0.size(), {req, " line0 entries"}, got_d0.size(), exp_d0.size());
    chk(got_d1.size() == exp_d1.size(), {req, " line1 entries"}, got_d1.size(), exp_d1.size());
    if (got_d0.size() == exp_d0.size())
      foreach (exp_d0[i]) chk(got_d0[i] == exp_d0[i], {req, " line0 entry"}, got_d0[i], exp_d0[i]);
    if (got_d1.size() == exp_d1.size())
      foreach (exp_d1[i]) chk(got_d1[i] == exp_d1[i], {req, " line1 entry"}, got_d1[i], exp_d1[i]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    cyc = 0; gate_mode = 0;
    out_ready = 1'b1; dl_ready = 2'b11;
    do_reset();
    @(negedge clk);
    chk(sync_locked == 2'b00, "R1 reset lock", sync_locked, 0);
    chk(out_valid == 1'b0 && dl_valid == 2'b00, "R8 reset empty", {out_valid, dl_valid}, 0);
    chk(polarity_inv == 2'b00 && !loops_swapped && crc_error == 2'b00, "R3 reset flags",
        {polarity_inv, loops_swapped, crc_error}, 0);

    // normal lines
    send_pairs(6, 1'b0, 1'b0, 1'b0, -1);
    drain();
    chk(sync_locked == 2'b11, "R1 lock", sync_locked, 2'b11);
    chk(polarity_inv == 2'b00, "R3 no inversion", polarity_inv, 0);
    chk(loops_swapped == 1'b0, "R4 not swapped", loops_swapped, 0);
    chk(crc_n0 + crc_n1 == 0, "R6 clean frames", crc_n0 + crc_n1, 0);
    cmp_words("R5");
    cmp_dl("R7");

    // inverted line 1 with enable gaps and random bits in the gaps
    do_reset();
    gate_mode = 1;
    send_pairs(6, 1'b0, 1'b0, 1'b1, -1);
    drain();
    gate_mode = 0;
    chk(polarity_inv == 2'b10, "R3 line1 inverted", polarity_inv, 2'b10);
    cmp_words("R3 R9");
    cmp_dl("R3 R9");

    // cross-connected lines
    do_reset();
    send_pairs(5, 1'b1, 1'b0, 1'b0, -1);
    drain();
    chk(loops_swapped == 1'b1, "R4 swapped", loops_swapped, 1);
    cmp_words("R4");
    cmp_dl("R7 physical line");

    // one corrupted frame on line 1
    do_reset();
    send_pairs(6, 1'b0, 1'b0, 1'b0, 3);
    drain();
    chk(crc_n1 == 1, "R6 line1 crc pulses", crc_n1, 1);
    chk(crc_n0 == 0, "R6 line0 crc pulses", crc_n0, 0);
    cmp_words("R6 forwarded");

    // back-pressure and overflow
    do_reset();
    @(posedge clk); #1 out_ready = 1'b0;
    send_pairs(8, 1'b0, 1'b0, 1'b0, -1);
    drain();
    chk(out_valid == 1'b1, "R8 valid under stall", out_valid, 1);
    chk(got_w.size() == 0, "R8 nothing taken under stall", got_w.size(), 0);
    while (exp_w.size() > 4) void'(exp_w.pop_back());
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    cmp_words("R8");

    // sync loss
    do_reset();
    send_pairs(4, 1'b0, 1'b0, 1'b0, -1);
    idle(0, 2*FL, 1'b0); idle(1, 2*FL, 1'b0);
    add_frame(0, 1'b0, 8'h3C, 2'b01, 1'b0, 1'b0);
    add_frame(1, 1'b1, 8'hC3, 2'b10, 1'b0, 1'b0);
    drain();
    chk(sync_locked == 2'b11, "R2 two misses kept", sync_locked, 2'b11);
    idle(0, 3*FL, 1'b0); idle(1, 3*FL, 1'b0);
    drain();
    chk(sync_locked == 2'b00, "R2 three misses lost", sync_locked, 0);

    summary();
    $finish;
  end
endmodule